// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns one stereo serial audio lane into parallel samples. The lane has three wires: a bit clock, a word clock whose level tells the left channel from the right, and a serial data line. A faster system clock, synchronous with the bit and word clocks, samples all three. On each rising bit-clock edge, the block takes in one data bit. It delivers the left and right words of each frame, MSB-aligned in 32-bit outputs, with a one-cycle valid strobe.

Three framings are supported, chosen by a configuration input, and the sample length can be 16, 20, 24 or 32 bits. Another input sets which word-clock level marks the left channel. The receiver counts bit clocks in every word-clock half. It raises a sticky error when a half is too short for the chosen word length. Once the half length has settled, it raises a second sticky error if that length later changes. Either error stops further samples being delivered until reset.

Top module: `serial_audio_rx`

## Requirements
- R1: With `fmt_i` = 1 (left-justified), the MSB of each word is the bit taken on the first rising bit-clock edge after the word clock changes level, and the following bits come MSB first.
- R2: With `fmt_i` = 0 (I2S; code 3 behaves the same), the MSB is taken on the second rising bit-clock edge after the word-clock change, that is, one bit clock late.
- R3: With `fmt_i` = 2 (right-justified), the LSB is the bit taken on the last rising bit-clock edge before the next word-clock change, and leading bits beyond the word length are discarded.
- R4: `wlen_i` codes 0, 1, 2 and 3 select 16, 20, 24 and 32 bits. Each word appears on `left_o`/`right_o` MSB-aligned at bit 31, with unused low bits zero.
- R5: Data is taken on the rising edge of the bit clock. A value that changes together with the falling edge belongs to the next bit.
- R6: With `lr_pol_i` = 0, a low word clock marks the left channel. With `lr_pol_i` = 1, a high word clock marks the left channel.
- R7: `valid_o` pulses for exactly one system clock after each complete right-channel half that follows a complete left half. `left_o` and `right_o` change only in that cycle and hold their values otherwise.
- R8: If a complete word-clock half holds fewer rising bit-clock edges than the word length, `bck_err_o` is set. It stays set until reset, and no further `valid_o` pulses are issued. A half exactly as long as the word is accepted.
- R9: `locked_o` rises after two consecutive complete halves of equal length.
- R10: While locked, a complete half whose length differs from the locked length sets `tmg_err_o`. The flag is sticky until reset, it clears `locked_o`, and it blocks further `valid_o` pulses.
- R11: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, synchronous with the serial clocks |
| rst_n | input | 1 | Synchronous active-low reset |
| bck_i | input | 1 | Serial bit clock |
| lrck_i | input | 1 | Word clock (channel select) |
| sdata_i | input | 1 | Serial data |
| fmt_i | input | 2 | Framing: 0 I2S, 1 left-justified, 2 right-justified, 3 as 0 |
| wlen_i | input | 2 | Word length: 0=16, 1=20, 2=24, 3=32 bits |
| lr_pol_i | input | 1 | Word-clock level that marks the left channel |
| left_o | output | 32 | Last left sample, MSB-aligned |
| right_o | output | 32 | Last right sample, MSB-aligned |
| valid_o | output | 1 | One-cycle strobe for a new sample pair |
| locked_o | output | 1 | Half-frame length is stable |
| bck_err_o | output | 1 | Sticky: a half had too few bit clocks |
| tmg_err_o | output | 1 | Sticky: half length changed after lock |

## Verification
The checks assume that every bit-clock level lasts at least two system clocks. They also assume that the word clock and the data change only together with falling bit-clock edges, so every rising edge is seen once with settled data. The stimulus builds the bit clock from the system clock with two cycles high and two low, and it updates the word clock and data only while driving the bit clock low. The stream always starts with a short stretch at the right-channel level, so the first full half that is measured is a left half. Configuration is applied during reset and kept constant for the rest of the run.

// File: rtl/srx_pkg.sv
// Shared types and helpers for the serial audio receiver.
package srx_pkg;

    localparam int SMP_W  = 32;   // widest sample, also the output word width
    localparam int WLEN_W = 6;    // enough to hold SMP_W

    typedef enum logic [1:0] {
        FMT_I2S = 2'd0,
        FMT_LJ  = 2'd1,
        FMT_RJ  = 2'd2,
        FMT_ALT = 2'd3
    } fmt_e;

    // Decode the two-bit word length code into a bit count.
    function automatic logic [WLEN_W-1:0] wlen_bits(input logic [1:0] code);
        case (code)
            2'd0:    wlen_bits = WLEN_W'(16);
            2'd1:    wlen_bits = WLEN_W'(20);
            2'd2:    wlen_bits = WLEN_W'(24);
            default: wlen_bits = WLEN_W'(32);
        endcase
    endfunction

endpackage

// File: rtl/srx_edge_sync.sv
// Registers the serial inputs and finds rising bit-clock edges.
// Assumes the serial clocks are synchronous with clk and that every
// bit-clock level lasts at least one clk period.
module srx_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic bck_i,
    input  logic lrck_i,
    input  logic sdata_i,
    output logic bck_rise,
    output logic lrck_smp,
    output logic sd_smp
);

    logic bck_s, bck_p;

    // Capture the raw inputs once per system clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bck_s    <= 1'b0;
            bck_p    <= 1'b0;
            lrck_smp <= 1'b0;
            sd_smp   <= 1'b0;
        end else begin
            bck_s    <= bck_i;
            bck_p    <= bck_s;
            lrck_smp <= lrck_i;
            sd_smp   <= sdata_i;
        end
    end

    // Rising edge: high now, low one clock earlier.
    always_comb bck_rise = bck_s & ~bck_p;

endmodule

// File: rtl/srx_frame_track.sv
// Tracks word-clock halves. It counts bit clocks per half, flags short
// halves, locks onto a stable half length and flags later changes.
// Assumes bck_rise marks each rising bit-clock edge exactly once.
module srx_frame_track #(
    parameter int CNT_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bck_rise,
    input  logic                      lrck_smp,
    input  logic [srx_pkg::WLEN_W-1:0] wlen,
    input  logic                      lr_pol,
    output logic                      boundary,
    output logic [CNT_W-1:0]          bit_idx,
    output logic                      half_done,
    output logic                      prev_left,
    output logic                      half_bad,
    output logic                      bck_err,
    output logic                      tmg_err,
    output logic                      locked
);

    logic             started, aligned, have_ref, lock_r, lrck_last;
    logic [CNT_W-1:0] bitcnt, ref_len, wl_ext;
    logic             short_h, mism;

    // Decode the half boundary and judge the half that just ended.
    always_comb begin
        wl_ext    = CNT_W'(wlen);
        boundary  = bck_rise & started & (lrck_smp != lrck_last);
        half_done = boundary & aligned;
        bit_idx   = boundary ? '0 : bitcnt;
        prev_left = (lrck_last == lr_pol);
        short_h   = (bitcnt < wl_ext);
        mism      = lock_r & (bitcnt != ref_len);
        half_bad  = half_done & (short_h | mism);
        locked    = lock_r & ~tmg_err;
    end

    // Count bit clocks within the current half, saturating at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started   <= 1'b0;
            aligned   <= 1'b0;
            lrck_last <= 1'b0;
            bitcnt    <= '0;
        end else if (bck_rise) begin
            started   <= 1'b1;
            lrck_last <= lrck_smp;
            if (boundary) begin
                aligned <= 1'b1;
                bitcnt  <= CNT_W'(1);
            end else if (bitcnt != '1) begin
                bitcnt  <= bitcnt + CNT_W'(1);
            end
        end
    end

    // Lock to the half length and raise the sticky error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_ref <= 1'b0;
            lock_r   <= 1'b0;
            ref_len  <= '0;
            bck_err  <= 1'b0;
            tmg_err  <= 1'b0;
        end else if (half_done) begin
            if (short_h)
                bck_err <= 1'b1;
            if (!have_ref) begin
                have_ref <= 1'b1;
                ref_len  <= bitcnt;
            end else if (lock_r) begin
                if (mism) begin
                    tmg_err <= 1'b1;
                    lock_r  <= 1'b0;
                end
            end else if (!tmg_err) begin
                if (bitcnt == ref_len)
                    lock_r  <= 1'b1;
                else
                    ref_len <= bitcnt;
            end
        end
    end

endmodule

// File: rtl/srx_word_capture.sv
// Shifts serial bits inside the framing window and assembles left/right
// pairs. Assumes boundary and half_done come from srx_frame_track in
// the same cycle as bck_rise.
module srx_word_capture #(
    parameter int CNT_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bck_rise,
    input  logic                       sd_smp,
    input  logic                       boundary,
    input  logic [CNT_W-1:0]           bit_idx,
    input  logic                       half_done,
    input  logic                       prev_left,
    input  logic                       half_bad,
    input  logic                       err_any,
    input  logic [1:0]                 fmt,
    input  logic [srx_pkg::WLEN_W-1:0] wlen,
    output logic [srx_pkg::SMP_W-1:0]  left_o,
    output logic [srx_pkg::SMP_W-1:0]  right_o,
    output logic                       valid_o
);
    import srx_pkg::*;

    localparam logic [WLEN_W-1:0] FULL = WLEN_W'(SMP_W);

    logic [SMP_W-1:0]  shreg, stage, aligned_w;
    logic [CNT_W-1:0]  wl_ext;
    logic              in_win, have_left;
    logic [WLEN_W-1:0] sh_amt;

    // Decide whether the current bit lies in the sample window.
    always_comb begin
        wl_ext = CNT_W'(wlen);
        case (fmt_e'(fmt))
            FMT_LJ:  in_win = (bit_idx < wl_ext);
            FMT_RJ:  in_win = 1'b1;
            default: in_win = (bit_idx != '0) && (bit_idx <= wl_ext);
        endcase
    end

    // Move the last wlen bits of the shifter up to the MSB end.
    always_comb begin
        sh_amt    = FULL - wlen;
        aligned_w = shreg << sh_amt;
    end

    // Collect serial bits; start afresh on every half boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (bck_rise) begin
            if (boundary)
                shreg <= in_win ? {{(SMP_W-1){1'b0}}, sd_smp} : '0;
            else if (in_win)
                shreg <= {shreg[SMP_W-2:0], sd_smp};
        end
    end

    // Pair a finished left word with the following right word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage     <= '0;
            have_left <= 1'b0;
            left_o    <= '0;
            right_o   <= '0;
            valid_o   <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (half_done) begin
                if (half_bad || err_any) begin
                    have_left <= 1'b0;
                end else if (prev_left) begin
                    stage     <= aligned_w;
                    have_left <= 1'b1;
                end else begin
                    if (have_left) begin
                        left_o  <= stage;
                        right_o <= aligned_w;
                        valid_o <= 1'b1;
                    end
                    have_left <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/serial_audio_rx.sv
// Top of the multi-format serial audio receiver. It joins the edge
// finder, the frame tracker and the word capture.
// Assumes configuration is held constant while the lane runs.
module serial_audio_rx #(
    parameter int CNT_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bck_i,
    input  logic                      lrck_i,
    input  logic                      sdata_i,
    input  logic [1:0]                fmt_i,
    input  logic [1:0]                wlen_i,
    input  logic                      lr_pol_i,
    output logic [srx_pkg::SMP_W-1:0] left_o,
    output logic [srx_pkg::SMP_W-1:0] right_o,
    output logic                      valid_o,
    output logic                      locked_o,
    output logic                      bck_err_o,
    output logic                      tmg_err_o
);
    import srx_pkg::*;

    logic              bck_rise, lrck_smp, sd_smp;
    logic              boundary, half_done, prev_left, half_bad;
    logic [CNT_W-1:0]  bit_idx;
    logic [WLEN_W-1:0] wlen;
    logic              err_any;

    // Decode the word length and merge the sticky errors.
    always_comb begin
        wlen    = wlen_bits(wlen_i);
        err_any = bck_err_o | tmg_err_o;
    end

    srx_edge_sync u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .bck_i    (bck_i),
        .lrck_i   (lrck_i),
        .sdata_i  (sdata_i),
        .bck_rise (bck_rise),
        .lrck_smp (lrck_smp),
        .sd_smp   (sd_smp)
    );

    srx_frame_track #(.CNT_W(CNT_W)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .bck_rise  (bck_rise),
        .lrck_smp  (lrck_smp),
        .wlen      (wlen),
        .lr_pol    (lr_pol_i),
        .boundary  (boundary),
        .bit_idx   (bit_idx),
        .half_done (half_done),
        .prev_left (prev_left),
        .half_bad  (half_bad),
        .bck_err   (bck_err_o),
        .tmg_err   (tmg_err_o),
        .locked    (locked_o)
    );

    srx_word_capture #(.CNT_W(CNT_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .bck_rise  (bck_rise),
        .sd_smp    (sd_smp),
        .boundary  (boundary),
        .bit_idx   (bit_idx),
        .half_done (half_done),
        .prev_left (prev_left),
        .half_bad  (half_bad),
        .err_any   (err_any),
        .fmt       (fmt_i),
        .wlen      (wlen),
        .left_o    (left_o),
        .right_o   (right_o),
        .valid_o   (valid_o)
    );

endmodule

// File: rtl/serial_audio_rx_chk.sv
// Property checker for serial_audio_rx, attached by bind.
module serial_audio_rx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bck_i,
    input logic [31:0] left_o,
    input logic [31:0] right_o,
    input logic        valid_o,
    input logic        locked_o,
    input logic        bck_err_o,
    input logic        tmg_err_o
);

    // Input assumption behind R5: each bit-clock high lasts two clocks.
    a_r5_bck_high_two: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bck_i) |=> bck_i);

    a_r7_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    a_r7_left_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(left_o));

    a_r7_right_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(right_o));

    a_r8_bck_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        bck_err_o |=> bck_err_o);

    a_r8_valid_clean: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (!bck_err_o && !tmg_err_o));

    a_r10_tmg_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        tmg_err_o |=> tmg_err_o);

    a_r10_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        tmg_err_o |-> !locked_o);

endmodule

bind serial_audio_rx serial_audio_rx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bck_i     (bck_i),
    .left_o    (left_o),
    .right_o   (right_o),
    .valid_o   (valid_o),
    .locked_o  (locked_o),
    .bck_err_o (bck_err_o),
    .tmg_err_o (tmg_err_o)
);

// File: tb/serial_audio_rx_test.sv
module serial_audio_rx_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bck = 1'b0, lrck = 1'b0, sdata = 1'b0;
    logic [1:0]  fmt = 2'd0, wlen = 2'd0;
    logic        pol = 1'b0;
    logic [31:0] left_o, right_o;
    logic        valid_o, locked_o, bck_err_o, tmg_err_o;

    int checks = 0, errors = 0;
    int vcount = 0, run = 0, maxrun = 0;

    always #5 clk = ~clk;

    serial_audio_rx uut (
        .clk(clk), .rst_n(rst_n), .bck_i(bck), .lrck_i(lrck), .sdata_i(sdata),
        .fmt_i(fmt), .wlen_i(wlen), .lr_pol_i(pol),
        .left_o(left_o), .right_o(right_o), .valid_o(valid_o),
        .locked_o(locked_o), .bck_err_o(bck_err_o), .tmg_err_o(tmg_err_o)
    );

    // Count valid pulses and the longest run of valid.
    always @(negedge clk) begin
        if (!rst_n) begin
            vcount = 0; run = 0; maxrun = 0;
        end else if (valid_o) begin
            vcount = vcount + 1; run = run + 1;
            if (run > maxrun) maxrun = run;
        end else begin
            run = 0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(negedge clk);
        errors = errors + 1;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
    end

    function automatic int wbits(input logic [1:0] c);
        return (c == 2'd3) ? 32 : 16 + 4 * int'(c);
    endfunction

    // Bit k of a half of hb bits carrying word v of w bits.
    function automatic logic bit_of(input logic [1:0] f, input int w, input int hb,
                                    input int k, input logic [31:0] v);
        if (f == 2'd1)      return (k < w) ? v[w-1-k] : 1'b0;
        else if (f == 2'd2) return (k >= hb - w) ? v[hb-1-k] : 1'b0;
        else                return (k >= 1 && k <= w) ? v[w-k] : 1'b0;
    endfunction

    task automatic send_bit(input logic lr, input logic d);
        @(negedge clk); bck = 1'b0; lrck = lr; sdata = d;
        @(negedge clk);
        @(negedge clk); bck = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] f, input logic [1:0] w, input logic p);
        @(negedge clk);
        rst_n = 1'b0; fmt = f; wlen = w; pol = p; bck = 1'b0; lrck = ~p; sdata = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        send_bit(~p, 1'b0);
        send_bit(~p, 1'b0);
    endtask

    task automatic send_frame(input int hbl, input int hbr,
                              input logic [31:0] lv, input logic [31:0] rv);
        int w;
        w = wbits(wlen);
        for (int k = 0; k < hbl; k++) send_bit(pol, bit_of(fmt, w, hbl, k, lv));
        for (int k = 0; k < hbr; k++) send_bit(~pol, bit_of(fmt, w, hbr, k, rv));
    endtask

    task automatic tail();
        send_bit(pol, 1'b0);
        repeat (6) @(negedge clk);
    endtask

    typedef struct packed {
        logic [1:0]  f;
        logic [1:0]  wl;
        logic [7:0]  hb;
        logic        p;
        logic [31:0] lv;
        logic [31:0] rv;
    } vec_t;

    // fmt: 0 I2S, 1 LJ, 2 RJ; wl: 0=16 1=20 2=24 3=32
    localparam vec_t VECS [8] = '{
        '{2'd1, 2'd0, 8'd32, 1'b0, 32'h0000A5C3, 32'h00003C5A},
        '{2'd0, 2'd2, 8'd32, 1'b0, 32'h008F1234, 32'h000ABCDE},
        '{2'd2, 2'd1, 8'd32, 1'b1, 32'h000FEDCB, 32'h00012345},
        '{2'd2, 2'd0, 8'd24, 1'b0, 32'h00008001, 32'h00007FFE},
        '{2'd1, 2'd3, 8'd32, 1'b1, 32'hDEADBEEF, 32'h01234567},
        '{2'd0, 2'd0, 8'd20, 1'b1, 32'h0000C001, 32'h00000FF0},
        '{2'd0, 2'd3, 8'd34, 1'b0, 32'h80000001, 32'h7FFFFFFE},
        '{2'd1, 2'd0, 8'd16, 1'b0, 32'h00009669, 32'h00001E87}
    };

    initial begin
        int w;
        // R11: reset state
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R11 left", left_o, 32'h0);
        chk("R11 right", right_o, 32'h0);
        chk("R11 flags", {28'h0, valid_o, locked_o, bck_err_o, tmg_err_o}, 32'h0);

        // Table: R1 LJ, R2 I2S, R3 RJ, R4 lengths, R5 rising edge, R6 polarity, R9 lock
        foreach (VECS[i]) begin
            do_reset(VECS[i].f, VECS[i].wl, VECS[i].p);
            w = wbits(VECS[i].wl);
            for (int n = 0; n < 3; n++)
                send_frame(int'(VECS[i].hb), int'(VECS[i].hb), VECS[i].lv, VECS[i].rv);
            tail();
            chk($sformatf("R1 R2 R3 R4 R5 R6 left vec%0d", i), left_o, VECS[i].lv << (32 - w));
            chk($sformatf("R1 R2 R3 R4 R5 R6 right vec%0d", i), right_o, VECS[i].rv << (32 - w));
            chk($sformatf("R7 pulses vec%0d", i), vcount, 3);
            chk($sformatf("R9 locked vec%0d", i), locked_o, 1);
            chk($sformatf("R8 R10 no error vec%0d", i), {bck_err_o, tmg_err_o}, 0);
        end
        chk("R7 single-cycle valid", maxrun, 1);

        // R8: halves shorter than the word length
        do_reset(2'd1, 2'd0, 1'b0);
        send_frame(12, 12, 32'hFFF, 32'hFFF);
        send_frame(12, 12, 32'hFFF, 32'hFFF);
        tail();
        chk("R8 short half flagged", bck_err_o, 1);
        chk("R8 no pulse on short", vcount, 0);
        send_frame(32, 32, 32'h1234, 32'h4321);
        send_frame(32, 32, 32'h1234, 32'h4321);
        tail();
        chk("R8 sticky", bck_err_o, 1);
        chk("R8 still no pulse", vcount, 0);
        chk("R8 outputs untouched", left_o, 32'h0);

        // R10: half length change after lock
        do_reset(2'd1, 2'd0, 1'b0);
        send_frame(32, 32, 32'h1111, 32'h2222);
        send_frame(32, 32, 32'h3333, 32'h4444);
        send_bit(pol, 1'b0);
        repeat (6) @(negedge clk);
        chk("R9 locked before change", locked_o, 1);
        chk("R10 clean before change", tmg_err_o, 0);
        // the bit already sent starts the left half; 27 more make 28
        for (int k = 1; k < 28; k++) send_bit(pol, 1'b1);
        for (int k = 0; k < 32; k++) send_bit(~pol, 1'b0);
        tail();
        chk("R10 timing error set", tmg_err_o, 1);
        chk("R10 lock cleared", locked_o, 0);
        chk("R10 no short-half error", bck_err_o, 0);
        chk("R10 pulses stop", vcount, 2);
        chk("R10 last left kept", left_o, 32'h33330000);
        send_frame(32, 32, 32'h5555, 32'h6666);
        send_frame(32, 32, 32'h5555, 32'h6666);
        tail();
        chk("R10 sticky", tmg_err_o, 1);
        chk("R10 still blocked", vcount, 2);

        summary();
    end

endmodule